// File: doc/BRIEF.md
# Serial Overhead Capture for OTN Transmit Path

This block runs on the fast transmit FEC clock. It divides that clock by three into a one-in-three clock enable, and it drives the same slow rate out of the block as the overhead clock. An external device uses that clock to return a frame-sync pulse and a serial overhead data stream. The block samples both lines once per slow period, at the fast edge where the overhead clock rises.

A frame lasts 680 slow cycles. Each of the four OTUk rows contributes a field of 128 bits (16 bytes), and each field is followed by 42 idle bits. The block collects the four row fields, most significant bit first, into a 512-bit shift register and drops the idle bits. Once the last row bit (cycle 638) has been sampled, it copies the 64 bytes into a holding register and raises a one-cycle ready strobe. The insertion logic downstream takes the overhead set from that holding register.

The position counter restarts on every frame sync. When no sync arrives, it keeps running past cycle 680 and wraps on its own. A sync that does not land on the expected wrap sets a sticky misalignment flag and realigns the counter. Nothing is captured until the first sync after reset.

Top module: `ohrx_top`

## Requirements
- R1: `oh_clk` has a period of 3 fast cycles: high for 2 cycles, then low for 1. Both serial inputs are sampled at the fast clock edge where `oh_clk` goes from low to high.
- R2: A high `oh_fs` at a sampling edge marks that bit as frame cycle 1 and restarts the cycle count.
- R3: The bits of cycles 1–128, 171–298, 341–468 and 511–638 form a 512-bit overhead set in arrival order. The first bit received lands in `oh_data[511]`, so byte 0 occupies `oh_data[511:504]` with its MSB first.
- R4: Bits of cycles 129–170, 299–340, 469–510 and 639–680 have no effect on `oh_data`, whatever their value.
- R5: When cycle 638 is sampled, `oh_data` takes the new set and `oh_valid` goes high, both on that same fast edge. `oh_valid` stays high for exactly one fast cycle.
- R6: `oh_data` changes only on a fast edge where `oh_valid` becomes high. Between strobes it holds its value.
- R7: When no sync arrives after cycle 680, the count wraps to cycle 1 and capture continues with the same layout.
- R8: A sync sampled while the count is not at 680 sets `oh_misalign`, which then stays set until reset. A frame cut short by an early sync produces no strobe.
- R9: Until the first sync after reset, no bit is captured, `oh_valid` stays low and `oh_misalign` stays low.
- R10: During reset and right after it, `oh_valid`, `oh_misalign` and `oh_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast transmit FEC clock |
| rst | input | 1 | Synchronous active-high reset |
| oh_clk | output | 1 | Overhead clock (fast clock divided by 3) |
| oh_fs | input | 1 | Serial frame sync, high on cycle 1 |
| oh_sd | input | 1 | Serial overhead data, MSB first |
| oh_valid | output | 1 | One-cycle strobe: new overhead set in `oh_data` |
| oh_data | output | 512 | Held overhead set, byte 0 in the top bits |
| oh_misalign | output | 1 | Sticky flag for a sync seen off the 680-cycle wrap |

## Verification
The hardest case to reach from the ports is a misaligned sync. The stimulus has to be in lockstep with the slow clock, fill part of a frame, and then break off at a count well away from the wrap. The bench does this by cutting one frame off at cycle 400 and starting the next with a sync. It then checks three things: the flag sets, the cut-off frame produces no strobe, and the realigned frame is captured cleanly. A further frame is sent without any sync, to show that the free-running wrap alone keeps the layout in place.

// File: rtl/ohrx_pkg.sv
package ohrx_pkg;

    localparam int DIV_RATIO  = 3;
    localparam int ROWS       = 4;
    localparam int ROW_BITS   = 128;
    localparam int IDLE_BITS  = 42;
    localparam int ROW_PERIOD = ROW_BITS + IDLE_BITS;
    localparam int FRAME_LEN  = ROWS * ROW_PERIOD;
    localparam int SET_BITS   = ROWS * ROW_BITS;
    localparam int CNT_W      = $clog2(FRAME_LEN + 1);

    typedef logic [CNT_W-1:0] slot_cnt_t;

    typedef struct packed {
        logic in_field;
        logic last_bit;
    } slot_info_t;

    function automatic slot_info_t decode_slot(input slot_cnt_t c);
        slot_info_t r;
        int off;
        int row;
        int col;
        off = int'(c) - 1;
        row = off / ROW_PERIOD;
        col = off % ROW_PERIOD;
        r.in_field = (col < ROW_BITS);
        r.last_bit = (row == ROWS - 1) && (col == ROW_BITS - 1);
        return r;
    endfunction

endpackage

// File: rtl/ohrx_clkdiv.sv
module ohrx_clkdiv #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst,
    output logic ce,
    output logic slow_clk
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HI   = (DIV + 1) / 2;

    logic [PH_W-1:0] phase;

    assign ce       = (phase == PH_W'(DIV - 1));
    assign slow_clk = (phase < PH_W'(HI));

    always_ff @(posedge clk) begin
        if (rst)     phase <= '0;
        else if (ce) phase <= '0;
        else         phase <= phase + 1'b1;
    end

    // Independent spacing counter used only by the check below
    logic [PH_W:0] gap;
    logic          seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (ce) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    a_r1_ce_spacing: assert property (@(posedge clk) disable iff (rst)
        (ce && seen) |-> (gap == (PH_W+1)'(DIV - 1)));
    a_r1_rise_at_sample: assert property (@(posedge clk) disable iff (rst)
        ce |=> slow_clk);

endmodule

// File: rtl/ohrx_framer.sv
module ohrx_framer
    import ohrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       fs,
    output logic       tick,
    output slot_info_t info,
    output logic       armed,
    output logic       misalign
);
    slot_cnt_t cnt;
    slot_cnt_t cur;
    logic      active;

    assign active = fs | armed;
    assign tick   = ce & active;

    always_comb begin
        if (fs || cnt == slot_cnt_t'(FRAME_LEN)) cur = slot_cnt_t'(1);
        else                                     cur = cnt + 1'b1;
    end

    assign info = decode_slot(cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b0;
            misalign <= 1'b0;
        end else if (tick) begin
            cnt   <= cur;
            armed <= 1'b1;
            if (fs && armed && cnt != slot_cnt_t'(FRAME_LEN))
                misalign <= 1'b1;
        end
    end

    a_r2_sync_restart: assert property (@(posedge clk) disable iff (rst)
        (ce && fs) |=> (cnt == slot_cnt_t'(1)));
    a_r7_free_wrap: assert property (@(posedge clk) disable iff (rst)
        (ce && armed && !fs && cnt == slot_cnt_t'(FRAME_LEN)) |=> (cnt == slot_cnt_t'(1)));
    a_r9_idle_count: assert property (@(posedge clk) disable iff (rst)
        armed |-> (cnt >= slot_cnt_t'(1) && cnt <= slot_cnt_t'(FRAME_LEN)));
    a_r9_no_flag_unarmed: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !misalign);

endmodule

// File: rtl/ohrx_deser.sv
module ohrx_deser
    import ohrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  slot_info_t          info,
    input  logic                sd,
    output logic                set_valid,
    output logic [SET_BITS-1:0] set_data
);
    logic [SET_BITS-1:0] shreg;
    logic [SET_BITS-1:0] shreg_nx;

    assign shreg_nx = {shreg[SET_BITS-2:0], sd};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            set_data  <= '0;
            set_valid <= 1'b0;
        end else begin
            set_valid <= 1'b0;
            if (tick && info.in_field) begin
                shreg <= shreg_nx;
                if (info.last_bit) begin
                    set_data  <= shreg_nx;
                    set_valid <= 1'b1;
                end
            end
        end
    end

    a_r4_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
        (tick && !info.in_field) |=> $stable(shreg));

endmodule

// File: rtl/ohrx_top.sv
module ohrx_top
    import ohrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    output logic                oh_clk,
    input  logic                oh_fs,
    input  logic                oh_sd,
    output logic                oh_valid,
    output logic [SET_BITS-1:0] oh_data,
    output logic                oh_misalign
);
    logic       ce;
    logic       tick;
    logic       armed;
    slot_info_t info;

    ohrx_clkdiv #(.DIV(DIV_RATIO)) u_div (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .slow_clk (oh_clk)
    );

    ohrx_framer u_frm (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .fs       (oh_fs),
        .tick     (tick),
        .info     (info),
        .armed    (armed),
        .misalign (oh_misalign)
    );

    ohrx_deser u_des (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .info      (info),
        .sd        (oh_sd),
        .set_valid (oh_valid),
        .set_data  (oh_data)
    );

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        oh_valid |=> !oh_valid);
    a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
        !$stable(oh_data) |-> oh_valid);
    a_r8_sticky_flag: assert property (@(posedge clk) disable iff (rst)
        oh_misalign |=> oh_misalign);
    a_r9_no_strobe_unarmed: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !oh_valid);

endmodule

// File: tb/ohrx_top_tb_top.sv
module ohrx_top_tb_top;
    localparam int NB = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          oh_clk;
    logic          oh_fs = 1'b0;
    logic          oh_sd = 1'b0;
    logic          oh_valid;
    logic [NB-1:0] oh_data;
    logic          oh_misalign;

    int n_chk = 0;
    int n_bad = 0;
    logic [NB-1:0] exp_q[$];
    logic [NB-1:0] last_data = '0;
    logic          prev_valid = 1'b0;
    int            strobes = 0;

    always #2.5 clk = ~clk;

    ohrx_top dut_i (
        .clk(clk), .rst(rst), .oh_clk(oh_clk), .oh_fs(oh_fs), .oh_sd(oh_sd),
        .oh_valid(oh_valid), .oh_data(oh_data), .oh_misalign(oh_misalign)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected sets as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (oh_valid && prev_valid)
                check(1'b0, "R5", "strobe wider than one cycle", 2, 1);
            if (oh_valid) begin
                strobes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected strobe", 1, 0);
                end else begin
                    logic [NB-1:0] e;
                    e = exp_q.pop_front();
                    check(oh_data === e, "R3", "captured set (R4 idle ignored)", oh_data, e);
                    last_data = e;
                end
            end
        end
        prev_valid = oh_valid;
    end

    task automatic slot(input logic fs, input logic d);
        @(negedge clk);
        while (oh_clk) @(negedge clk);
        oh_fs = fs;
        oh_sd = d;
    endtask

    function automatic logic [NB-1:0] rand_set();
        logic [NB-1:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    // idle_mode: 0 zeros, 1 ones, 2 random
    task automatic send_frame(input logic [NB-1:0] d, input int idle_mode,
                              input bit with_sync, input int stop_at);
        if (stop_at >= 638) exp_q.push_back(d);
        for (int s = 1; s <= stop_at; s++) begin
            int row;
            int col;
            logic b;
            row = (s - 1) / 170;
            col = (s - 1) % 170;
            if (col < 128)           b = d[NB-1 - (row*128 + col)];
            else if (idle_mode == 0) b = 1'b0;
            else if (idle_mode == 1) b = 1'b1;
            else                     b = 1'($urandom);
            slot(with_sync && s == 1, b);
            if (s == 300)
                check(oh_data === last_data, "R6", "held set mid-frame", oh_data, last_data);
            if (s == 638) begin
                @(posedge clk);
                @(negedge clk);
                check(oh_valid === 1'b1, "R5", "strobe after cycle 638", NB'(oh_valid), 1);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NB-1:0] pa;
        int hi_n;
        int per;
        for (int i = 0; i < 64; i++) pa[NB-1-8*i -: 8] = 8'(i * 37 + 5);

        repeat (5) @(posedge clk);
        @(negedge clk);
        check(oh_valid === 1'b0 && oh_misalign === 1'b0 && oh_data === '0,
              "R10", "reset outputs", oh_data, '0);
        rst = 1'b0;
        @(negedge clk);
        check(oh_valid === 1'b0 && oh_misalign === 1'b0 && oh_data === '0,
              "R10", "outputs after reset", oh_data, '0);

        // R1: overhead clock shape
        for (int k = 0; k < 2; k++) begin
            while (oh_clk) @(negedge clk);
            while (!oh_clk) @(negedge clk);
            hi_n = 0;
            per  = 0;
            while (oh_clk) begin hi_n++; per++; @(negedge clk); end
            while (!oh_clk) begin per++; @(negedge clk); end
            check(per == 3 && hi_n == 2, "R1", "oh_clk period/high",
                  NB'(per * 16 + hi_n), NB'(3 * 16 + 2));
        end

        // R9: no capture before first sync
        for (int s = 0; s < 700; s++) slot(1'b0, 1'($urandom));
        repeat (4) @(negedge clk);
        check(strobes == 0 && oh_misalign === 1'b0 && oh_data === '0, "R9",
              "activity before first sync", NB'(strobes), 0);

        send_frame(pa, 1, 1'b1, 680);        // R2 sync-aligned, idle ones
        send_frame(~pa, 0, 1'b1, 680);       // R3 second pattern, idle zeros
        send_frame(rand_set(), 2, 1'b0, 680); // R7 free-running wrap
        check(oh_misalign === 1'b0, "R8", "no flag on aligned frames", NB'(oh_misalign), 0);

        send_frame(rand_set(), 2, 1'b1, 400); // cut short at cycle 400
        check(oh_misalign === 1'b0, "R8", "flag before early sync", NB'(oh_misalign), 0);
        send_frame(rand_set(), 2, 1'b1, 680); // early sync realigns
        check(oh_misalign === 1'b1, "R8", "flag after early sync", NB'(oh_misalign), 1);
        send_frame(rand_set(), 1, 1'b1, 680);
        check(oh_misalign === 1'b1, "R8", "flag sticky", NB'(oh_misalign), 1);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0 && strobes == 5, "R5", "strobe count",
              NB'(strobes), NB'(5));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule